// File: doc/BRIEF.md
# T1 Data-Link Remote Alarm Detector and Generator

This block handles the remote (yellow) alarm carried in the data-link bit positions of an extended-superframe T1/J1 line. On the receive side it takes the already extracted data-link bit stream, one bit per cycle in which `dl_valid` is high. It groups the bits into consecutive 16-bit windows, counted from reset. Each window is compared against the alarm pattern at every one of its 16 rotations. A window that differs from some rotation in at most one bit counts as a match. This lets the alarm survive a bit error rate of about one in a thousand.

A registered alarm flag rises after four consecutive matching windows. It falls after four consecutive windows that do not match. In the default mode the alarm pattern is eight ones followed by eight zeros. With `mode_jp` set, the Japanese variant applies and the pattern is sixteen ones.

On the transmit side, each `tx_strobe` marks one outgoing data-link slot. While `tx_alarm_en` is low the incoming data bit passes through. While it is high the slot carries the alarm pattern instead, starting at the first bit of the pattern each time the alarm is switched on. Framing, extraction of the data link from the frame and any register access sit outside this block.

Top module: `t1_remote_alarm`

## Requirements
- R1: After reset `rx_alarm` is 0 and `tx_dl_out` is 0.
- R2: With `mode_jp`=0 the alarm pattern, in time order, is eight ones then eight zeros, accepted at any of its 16 rotations. Windows are consecutive non-overlapping groups of 16 valid bits counted from reset. `rx_alarm` rises in the cycle after the strobe of the last bit of the fourth consecutive matching window. A stream of all ones never raises it in this mode.
- R3: A window that differs from the best-fitting rotation of the pattern in exactly one bit still counts as a match.
- R4: A window with two or more mismatching bits against every rotation is a non-match and restarts the count of matching windows.
- R5: `rx_alarm` falls after four consecutive non-matching windows. A matching window in between restarts that count.
- R6: With `mode_jp`=1 the receive pattern is sixteen ones. The eight-ones/eight-zeros pattern then does not raise the alarm.
- R7: `dl_bit` is ignored while `dl_valid` is 0, and `rx_alarm` changes only in the cycle after a `dl_valid` cycle.
- R8: `tx_dl_out` is registered and changes only in the cycle after a `tx_strobe` cycle. With `tx_alarm_en`=0 it takes the value of `tx_dl_bit`.
- R9: With `tx_alarm_en`=1 and the eight/eight pattern selected, successive strobes send eight ones then eight zeros, repeating every 16 strobes. The first strobe after enabling carries the first one, and `tx_dl_bit` is ignored.
- R10: Dropping `tx_alarm_en` returns the transmit phase to 0, so a later enable starts again at the first bit of the pattern.
- R11: The transmit pattern is sixteen ones when `mode_jp`=1 and `tx_alt_fmt`=0. In every other case it is eight ones then eight zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_jp | input | 1 | 1 selects the sixteen-ones (Japanese) alarm pattern |
| dl_valid | input | 1 | Marks a cycle carrying one received data-link bit |
| dl_bit | input | 1 | Received data-link bit |
| rx_alarm | output | 1 | Remote alarm detected |
| tx_strobe | input | 1 | Marks one outgoing data-link slot |
| tx_alarm_en | input | 1 | Replace outgoing data-link bits with the alarm pattern |
| tx_alt_fmt | input | 1 | In Japanese mode, 1 keeps the eight/eight transmit pattern |
| tx_dl_bit | input | 1 | Outgoing data-link bit to pass through |
| tx_dl_out | output | 1 | Outgoing data-link bit after alarm insertion |

## Verification
The assertions check the following on every cycle:
- the receive flag holds still without a valid bit, and never rises before 64 valid bits have arrived;
- the transmit output holds between strobes and copies the data bit when the alarm is off;
- the first slot after enabling the alarm is a one, and the Japanese transmit pattern is all ones.

Only the bench scenarios can show the window-level behaviour:
- which windows count as matches at a given error count and rotation;
- the four-window set and clear runs and their restart by an interrupting window;
- the exact eight/eight transmit sequence and its restart at phase 0.

// File: rtl/ra_pkg.sv
package ra_pkg;

    // Alarm pattern bit at position pos (0 = first in time) of a len-bit period.
    function automatic logic alarm_pat_bit(input logic all_ones, input int pos, input int len);
        return all_ones ? 1'b1 : (pos < (len / 2));
    endfunction

endpackage

// File: rtl/ra_window_match.sv
module ra_window_match #(
    parameter int LEN     = 16,
    parameter int MAX_ERR = 1
) (
    input  logic [LEN-1:0] window,   // bit LEN-1 is the oldest
    input  logic           all_ones,
    output logic           match
);
    import ra_pkg::*;

    localparam int CW = $clog2(LEN + 1);

    logic [LEN-1:0] hit;

    for (genvar k = 0; k < LEN; k++) begin : g_phase
        logic [LEN-1:0] expv;
        logic [CW-1:0]  errs;
        always_comb begin
            expv = '0;
            for (int t = 0; t < LEN; t++) begin
                expv[LEN-1-t] = alarm_pat_bit(all_ones, (t + k) % LEN, LEN);
            end
            errs = CW'($countones(window ^ expv));
        end
        assign hit[k] = (errs <= CW'(MAX_ERR));
    end

    assign match = |hit;

endmodule

// File: rtl/ra_rx_detect.sv
module ra_rx_detect #(
    parameter int LEN     = 16,
    parameter int MAX_ERR = 1,
    parameter int SET_RUN = 4,
    parameter int CLR_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_ones,
    input  logic dl_valid,
    input  logic dl_bit,
    output logic alarm
);
    localparam int PW  = $clog2(LEN);
    localparam int RUN = (SET_RUN > CLR_RUN) ? SET_RUN : CLR_RUN;
    localparam int RW  = $clog2(RUN + 1);

    typedef struct packed {
        logic [LEN-1:0] sr;
        logic [PW-1:0]  pos;
        logic [RW-1:0]  hits;
        logic [RW-1:0]  misses;
        logic           alarm;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [LEN-1:0] win_w;
    logic           match_w;

    assign win_w = {st_q.sr[LEN-2:0], dl_bit};

    ra_window_match #(.LEN(LEN), .MAX_ERR(MAX_ERR)) u_match (
        .window   (win_w),
        .all_ones (all_ones),
        .match    (match_w)
    );

    always_comb begin
        st_d = st_q;
        if (dl_valid) begin
            st_d.sr = win_w;
            if (st_q.pos == PW'(LEN - 1)) begin
                st_d.pos = '0;
                if (match_w) begin
                    st_d.misses = '0;
                    if (st_q.hits < RW'(SET_RUN)) st_d.hits = st_q.hits + 1'b1;
                    if (st_d.hits >= RW'(SET_RUN)) st_d.alarm = 1'b1;
                end else begin
                    st_d.hits = '0;
                    if (st_q.misses < RW'(CLR_RUN)) st_d.misses = st_q.misses + 1'b1;
                    if (st_d.misses >= RW'(CLR_RUN)) st_d.alarm = 1'b0;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm = st_q.alarm;

endmodule

// File: rtl/ra_tx_gen.sv
module ra_tx_gen #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_ones,
    input  logic strobe,
    input  logic alarm_en,
    input  logic data_bit,
    output logic dl_out
);
    import ra_pkg::*;

    localparam int PW = $clog2(LEN);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          out;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!alarm_en) st_d.phase = '0;
        if (strobe) begin
            if (alarm_en) begin
                st_d.out   = alarm_pat_bit(all_ones, int'(st_q.phase), LEN);
                st_d.phase = (st_q.phase == PW'(LEN - 1)) ? '0 : st_q.phase + 1'b1;
            end else begin
                st_d.out = data_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dl_out = st_q.out;

endmodule

// File: rtl/t1_remote_alarm.sv
module t1_remote_alarm #(
    parameter int LEN     = 16,
    parameter int MAX_ERR = 1,
    parameter int SET_RUN = 4,
    parameter int CLR_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_jp,
    input  logic dl_valid,
    input  logic dl_bit,
    output logic rx_alarm,
    input  logic tx_strobe,
    input  logic tx_alarm_en,
    input  logic tx_alt_fmt,
    input  logic tx_dl_bit,
    output logic tx_dl_out
);
    logic tx_all_ones;
    assign tx_all_ones = mode_jp & ~tx_alt_fmt;

    ra_rx_detect #(
        .LEN(LEN), .MAX_ERR(MAX_ERR), .SET_RUN(SET_RUN), .CLR_RUN(CLR_RUN)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .all_ones (mode_jp),
        .dl_valid (dl_valid),
        .dl_bit   (dl_bit),
        .alarm    (rx_alarm)
    );

    ra_tx_gen #(.LEN(LEN)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .all_ones (tx_all_ones),
        .strobe   (tx_strobe),
        .alarm_en (tx_alarm_en),
        .data_bit (tx_dl_bit),
        .dl_out   (tx_dl_out)
    );

endmodule

module ra_checker #(
    parameter int SET_BITS = 64
) (
    input logic clk,
    input logic rst_n,
    input logic mode_jp,
    input logic dl_valid,
    input logic rx_alarm,
    input logic tx_strobe,
    input logic tx_alarm_en,
    input logic tx_alt_fmt,
    input logic tx_dl_bit,
    input logic tx_dl_out
);
    localparam int SW = $clog2(SET_BITS + 1);
    logic [SW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                           seen_q <= '0;
        else if (dl_valid && seen_q < SW'(SET_BITS)) seen_q <= seen_q + 1'b1;
    end

    AST_RX_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_valid |=> $stable(rx_alarm)); // R7
    AST_RX_NO_EARLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_alarm) |-> seen_q >= SW'(SET_BITS)); // R2
    AST_TX_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_strobe |=> $stable(tx_dl_out)); // R8
    AST_TX_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && !tx_alarm_en) |=> tx_dl_out == $past(tx_dl_bit)); // R8
    AST_TX_FIRST_SLOT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && $rose(tx_alarm_en)) |=> tx_dl_out); // R9
    AST_TX_JP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && tx_alarm_en && mode_jp && !tx_alt_fmt) |=> tx_dl_out); // R11

endmodule

bind t1_remote_alarm ra_checker #(.SET_BITS(LEN * SET_RUN)) u_ra_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_jp     (mode_jp),
    .dl_valid    (dl_valid),
    .rx_alarm    (rx_alarm),
    .tx_strobe   (tx_strobe),
    .tx_alarm_en (tx_alarm_en),
    .tx_alt_fmt  (tx_alt_fmt),
    .tx_dl_bit   (tx_dl_bit),
    .tx_dl_out   (tx_dl_out)
);

// File: tb/tb_t1_remote_alarm.sv
module tb_t1_remote_alarm;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, mode_jp, dl_valid, dl_bit, rx_alarm;
    logic tx_strobe, tx_alarm_en, tx_alt_fmt, tx_dl_bit, tx_dl_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    t1_remote_alarm dut (
        .clk(clk), .rst_n(rst_n), .mode_jp(mode_jp), .dl_valid(dl_valid),
        .dl_bit(dl_bit), .rx_alarm(rx_alarm), .tx_strobe(tx_strobe),
        .tx_alarm_en(tx_alarm_en), .tx_alt_fmt(tx_alt_fmt),
        .tx_dl_bit(tx_dl_bit), .tx_dl_out(tx_dl_out)
    );

    // kind: 0 = eight ones then eight zeros, 1 = all ones, 2 = all zeros
    function automatic logic pat(input int kind, input int i);
        if (kind == 1) return 1'b1;
        if (kind == 2) return 1'b0;
        return (i % 16) < 8;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; mode_jp = 0; dl_valid = 0; dl_bit = 0;
        tx_strobe = 0; tx_alarm_en = 0; tx_alt_fmt = 0; tx_dl_bit = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        dl_valid = 1; dl_bit = b;
        @(negedge clk);
        dl_valid = 0; dl_bit = ~b;
    endtask

    task automatic send_window(input int kind, input int phase, input logic [15:0] err);
        for (int t = 0; t < 16; t++) send_bit(pat(kind, t + phase) ^ err[t]);
    endtask

    task automatic tx_slot(input logic data);
        @(negedge clk);
        tx_strobe = 1; tx_dl_bit = data;
        @(negedge clk);
        tx_strobe = 0;
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 rx_alarm after reset", rx_alarm, 1'b0);
        check("R1 tx_dl_out after reset", tx_dl_out, 1'b0);
    endtask

    task automatic test_normal_set();
        do_reset();
        for (int w = 0; w < 3; w++) send_window(0, 5, 16'h0);
        check("R2 three windows not enough", rx_alarm, 1'b0);
        send_window(0, 5, 16'h0);
        check("R2 set after fourth window", rx_alarm, 1'b1);
        do_reset();
        for (int w = 0; w < 5; w++) send_window(1, 0, 16'h0);
        check("R2 all ones ignored in normal mode", rx_alarm, 1'b0);
    endtask

    task automatic test_errors();
        do_reset();
        for (int w = 0; w < 4; w++) send_window(0, 11, 16'h1 << (w * 3 + 1));
        check("R3 one error per window tolerated", rx_alarm, 1'b1);
        do_reset();
        for (int w = 0; w < 3; w++) send_window(0, 2, 16'h0);
        send_window(0, 2, 16'h0101);
        for (int w = 0; w < 3; w++) send_window(0, 2, 16'h0);
        check("R4 two errors restart run", rx_alarm, 1'b0);
        send_window(0, 2, 16'h0);
        check("R4 set after four fresh windows", rx_alarm, 1'b1);
    endtask

    task automatic test_clear();
        do_reset();
        for (int w = 0; w < 4; w++) send_window(0, 0, 16'h0);
        for (int w = 0; w < 3; w++) send_window(2, 0, 16'h0);
        check("R5 three misses keep alarm", rx_alarm, 1'b1);
        send_window(0, 7, 16'h0);
        for (int w = 0; w < 3; w++) send_window(2, 0, 16'h0);
        check("R5 match restarts miss run", rx_alarm, 1'b1);
        send_window(2, 0, 16'h0);
        check("R5 clear after four misses", rx_alarm, 1'b0);
    endtask

    task automatic test_jp();
        do_reset();
        mode_jp = 1;
        for (int w = 0; w < 4; w++) send_window(1, 0, w == 2 ? 16'h0200 : 16'h0);
        check("R6 sixteen ones set in jp mode", rx_alarm, 1'b1);
        do_reset();
        mode_jp = 1;
        for (int w = 0; w < 5; w++) send_window(0, 0, 16'h0);
        check("R6 eight/eight ignored in jp mode", rx_alarm, 1'b0);
    endtask

    task automatic test_ignore();
        do_reset();
        for (int w = 0; w < 3; w++) send_window(0, 3, 16'h0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            dl_valid = 0; dl_bit = i[0];
        end
        check("R7 no change without valid", rx_alarm, 1'b0);
        send_window(0, 3, 16'h0);
        check("R7 invalid bits did not shift window", rx_alarm, 1'b1);
    endtask

    task automatic test_tx();
        do_reset();
        tx_slot(1'b1);
        check("R8 pass through one", tx_dl_out, 1'b1);
        @(negedge clk);
        tx_dl_bit = 0;
        repeat (3) @(negedge clk);
        check("R8 hold without strobe", tx_dl_out, 1'b1);
        tx_slot(1'b0);
        check("R8 pass through zero", tx_dl_out, 1'b0);
        @(negedge clk);
        tx_alarm_en = 1;
        for (int i = 0; i < 20; i++) begin
            tx_slot(~pat(0, i));
            check($sformatf("R9 slot %0d", i), tx_dl_out, pat(0, i));
        end
        @(negedge clk);
        tx_alarm_en = 0;
        @(negedge clk);
        tx_alarm_en = 1;
        for (int i = 0; i < 4; i++) begin
            tx_slot(~pat(0, i));
            check($sformatf("R10 restart slot %0d", i), tx_dl_out, pat(0, i));
        end
        @(negedge clk);
        tx_alarm_en = 0; mode_jp = 1; tx_alt_fmt = 0;
        @(negedge clk);
        tx_alarm_en = 1;
        for (int i = 0; i < 16; i++) begin
            tx_slot(1'b0);
            check($sformatf("R11 jp ones slot %0d", i), tx_dl_out, 1'b1);
        end
        @(negedge clk);
        tx_alarm_en = 0; tx_alt_fmt = 1;
        @(negedge clk);
        tx_alarm_en = 1;
        for (int i = 0; i < 16; i++) begin
            tx_slot(~pat(0, i));
            check($sformatf("R11 alt fmt slot %0d", i), tx_dl_out, pat(0, i));
        end
    endtask

    initial begin
        test_reset();
        test_normal_set();
        test_errors();
        test_clear();
        test_jp();
        test_ignore();
        test_tx();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule